// File: doc/BRIEF.md
# Host Bridge Address Decoder and Interrupt Router

This block sits at the front of a host-to-PCI bridge. For each CPU access it picks one target region and gives the offset of the access inside that region. The regions are system memory, PCI I/O, the PCI memory window, a one-byte interrupt-acknowledge port and a read-only boot ROM at the top of the address space. An address that no region claims, a write to the ROM and an illegal acknowledge access all raise an error and select nothing. The CPU decode is purely combinational.

A second decoder handles addresses that PCI bus masters issue. The lower half of the space reaches the PCI memory window and the upper half reaches system RAM from address zero. A gap between the two raises an error.

The interrupt router takes the four level-sensitive interrupt pins of every slot. In legacy mode it swizzles them onto two of four separate lines. Otherwise it merges all of them onto one line. Both kinds of output are registered once.

Top module: `hb_bridge`

## Requirements
- R1: A valid CPU address below 0x8000_0000 selects system memory (select bit 0), and the offset equals the address.
- R2: A valid CPU address from 0x8000_0000 to 0xBF7F_FFFF selects PCI I/O (select bit 1), and the offset is the address minus 0x8000_0000.
- R3: A 1-byte read (size code 0) at 0xBFFF_FFF0 selects the acknowledge port (select bit 2) with offset 0, and `ack_data` shows `irq_vector`. A write there, or any size code other than 0, raises `cpu_err`, selects nothing, and `ack_data` stays 0.
- R4: A valid CPU address from 0xC000_0000 to 0xFEFF_FFFF selects PCI memory (select bit 3), and the offset is the address minus 0xC000_0000.
- R5: A read in the top ROM_BYTES of the space (by default 0xFFF0_0000 and above) selects the ROM (select bit 4), and the offset is the address minus the ROM base. A write there is dropped: `cpu_err` is raised and nothing is selected.
- R6: A valid address that no region claims raises `cpu_err` and selects nothing. These are 0xBF80_0000–0xBFFF_FFEF, 0xBFFF_FFF1–0xBFFF_FFFF and 0xFF00_0000–0xFFEF_FFFF. With `cpu_valid` low, neither a select nor an error is driven.
- R7: `cpu_sel` is one-hot or all zero.
- R8: A bus-master address below 0x3F00_0000 goes to PCI memory with offset equal to the address. An address at 0x8000_0000 or above goes to system memory with offset equal to the address minus 0x8000_0000. An address in between raises `bm_err`. Exactly one of the three outputs is high at any time.
- R9: In legacy mode, interrupt input index d*PINS+n (slot d, pin n) drives `irq_line[(n+d)&1]` one clock later. `irq_line[3:2]` and `irq_single` stay 0.
- R10: In merged mode, `irq_single` is the OR of all interrupt inputs one clock later, and `irq_line` is all zero.
- R11: While `rst_n` is sampled low, `irq_line` and `irq_single` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | CPU access present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| cpu_addr | input | 32 | CPU address |
| cpu_sel | output | 5 | One-hot region select (bit 0 sys, 1 PCI I/O, 2 ack, 3 PCI mem, 4 ROM) |
| cpu_offset | output | 32 | Offset inside selected region |
| cpu_err | output | 1 | Access error |
| irq_vector | input | 8 | Vector from the interrupt controller |
| ack_data | output | 8 | Read data of the acknowledge port |
| bm_addr | input | 32 | Bus-master address |
| bm_to_pci | output | 1 | Bus master targets PCI memory |
| bm_to_sys | output | 1 | Bus master targets system memory |
| bm_err | output | 1 | Bus-master address unmapped |
| bm_offset | output | 32 | Offset in the bus-master target |
| legacy_mode | input | 1 | 1 = separate lines, 0 = merged line |
| irq_in | input | SLOTS*PINS | Slot interrupt pins, index slot*PINS+pin |
| irq_line | output | 4 | Separate interrupt lines (legacy) |
| irq_single | output | 1 | Merged interrupt line |

## Verification
The bench builds the block with its defaults: four slots of four pins and a 1 MB ROM. Four slots cover both slot parities twice, so every pin lands on both swizzle targets. The bench checks the edges of each region, the addresses on either side of every boundary, the acknowledge byte and its neighbours, and the gaps. Each input pin is driven alone, in both routing modes, with a one-clock wait after each change.

// File: rtl/hb_pkg.sv
// Shared constants for the host bridge: region select indices and the fixed
// address map. Assumes a 32-bit CPU and bus-master address space.
package hb_pkg;
    localparam int RG_SYS  = 0;
    localparam int RG_PIO  = 1;
    localparam int RG_ACK  = 2;
    localparam int RG_PMEM = 3;
    localparam int RG_ROM  = 4;
    localparam int RG_N    = 5;

    localparam logic [31:0] PIO_BASE  = 32'h8000_0000;
    localparam logic [31:0] PIO_SPAN  = 32'h3F80_0000;
    localparam logic [31:0] ACK_ADDR  = 32'hBFFF_FFF0;
    localparam logic [31:0] PMEM_BASE = 32'hC000_0000;
    localparam logic [31:0] PMEM_SPAN = 32'h3F00_0000;
    localparam logic [31:0] BM_SPLIT  = 32'h8000_0000;

    localparam logic [1:0] SZ_BYTE = 2'd0;
endpackage

// File: rtl/hb_cpu_decode.sv
// CPU-side decoder: combinational region select and in-region offset.
// Assumes the ROM size is a power of two no larger than 16 MB, so the ROM
// sits above the PCI memory window.
module hb_cpu_decode
    import hb_pkg::*;
#(
    parameter logic [31:0] ROM_BYTES = 32'h0010_0000
) (
    input  logic              valid,
    input  logic              write,
    input  logic [1:0]        size,
    input  logic [31:0]       addr,
    input  logic [7:0]        vec_in,
    output logic [RG_N-1:0]   sel,
    output logic [31:0]       offset,
    output logic              err,
    output logic [7:0]        ack_data
);
    localparam logic [31:0] ROM_BASE = ~(ROM_BYTES - 32'd1);
    localparam logic [31:0] PIO_END  = PIO_BASE + PIO_SPAN;
    localparam logic [31:0] PMEM_END = PMEM_BASE + PMEM_SPAN;

    // Pick one region, or flag an error, for the current access.
    always_comb begin
        sel    = '0;
        offset = '0;
        err    = 1'b0;
        if (valid) begin
            if (addr < PIO_BASE) begin
                sel[RG_SYS] = 1'b1;
                offset      = addr;
            end else if (addr < PIO_END) begin
                sel[RG_PIO] = 1'b1;
                offset      = addr - PIO_BASE;
            end else if (addr == ACK_ADDR) begin
                if (!write && size == SZ_BYTE) sel[RG_ACK] = 1'b1;
                else                           err         = 1'b1;
            end else if (addr >= ROM_BASE) begin
                if (write) begin
                    err = 1'b1;
                end else begin
                    sel[RG_ROM] = 1'b1;
                    offset      = addr - ROM_BASE;
                end
            end else if (addr >= PMEM_BASE && addr < PMEM_END) begin
                sel[RG_PMEM] = 1'b1;
                offset       = addr - PMEM_BASE;
            end else begin
                err = 1'b1;
            end
        end
    end

    // Return the controller vector only on a legal acknowledge read.
    always_comb ack_data = sel[RG_ACK] ? vec_in : 8'h00;
endmodule

// File: rtl/hb_bm_decode.sv
// Bus-master decoder: the lower half reaches the PCI memory window, the
// upper half reaches system RAM from zero. Assumes the window starts at 0.
module hb_bm_decode
    import hb_pkg::*;
(
    input  logic [31:0] addr,
    output logic        to_pci,
    output logic        to_sys,
    output logic        err,
    output logic [31:0] offset
);
    // Classify the bus-master address and rebase it.
    always_comb begin
        to_pci = 1'b0;
        to_sys = 1'b0;
        err    = 1'b0;
        offset = '0;
        if (addr >= BM_SPLIT) begin
            to_sys = 1'b1;
            offset = addr - BM_SPLIT;
        end else if (addr < PMEM_SPAN) begin
            to_pci = 1'b1;
            offset = addr;
        end else begin
            err = 1'b1;
        end
    end
endmodule

// File: rtl/hb_irq_route.sv
// Interrupt router: swizzles slot pins onto lines (n+d)&1 in legacy mode,
// or merges all pins onto one line. Inputs are level-sensitive, outputs
// registered once. Assumes LINES >= 2.
module hb_irq_route #(
    parameter int SLOTS = 4,
    parameter int PINS  = 4,
    parameter int LINES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   legacy,
    input  logic [SLOTS*PINS-1:0]  irq_in,
    output logic [LINES-1:0]       irq_line,
    output logic                   irq_single
);
    logic [LINES-1:0] swz;

    // Gather each slot pin onto its swizzled line.
    always_comb begin
        swz = '0;
        for (int d = 0; d < SLOTS; d++) begin
            for (int n = 0; n < PINS; n++) begin
                swz[(n + d) % 2] = swz[(n + d) % 2] | irq_in[d*PINS + n];
            end
        end
    end

    // Register the outputs of the active mode and clear the other.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_line   <= '0;
            irq_single <= 1'b0;
        end else if (legacy) begin
            irq_line   <= swz;
            irq_single <= 1'b0;
        end else begin
            irq_line   <= '0;
            irq_single <= |irq_in;
        end
    end

    // R10
    merged_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy |=> (irq_single == $past(|irq_in)) && (irq_line == '0));
    // R9
    legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy |=> !irq_single && (irq_line[LINES-1:2] == '0));
    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_line == '0) && !irq_single);
endmodule

// File: rtl/hb_bridge.sv
// Host bridge top: CPU address decode, bus-master decode and interrupt
// routing. Decode paths are combinational; interrupt outputs are registered.
module hb_bridge
    import hb_pkg::*;
#(
    parameter int          SLOTS     = 4,
    parameter int          PINS      = 4,
    parameter logic [31:0] ROM_BYTES = 32'h0010_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    input  logic                   cpu_write,
    input  logic [1:0]             cpu_size,
    input  logic [31:0]            cpu_addr,
    output logic [4:0]             cpu_sel,
    output logic [31:0]            cpu_offset,
    output logic                   cpu_err,
    input  logic [7:0]             irq_vector,
    output logic [7:0]             ack_data,
    input  logic [31:0]            bm_addr,
    output logic                   bm_to_pci,
    output logic                   bm_to_sys,
    output logic                   bm_err,
    output logic [31:0]            bm_offset,
    input  logic                   legacy_mode,
    input  logic [SLOTS*PINS-1:0]  irq_in,
    output logic [3:0]             irq_line,
    output logic                   irq_single
);
    hb_cpu_decode #(.ROM_BYTES(ROM_BYTES)) u_cpu (
        .valid(cpu_valid), .write(cpu_write), .size(cpu_size), .addr(cpu_addr),
        .vec_in(irq_vector), .sel(cpu_sel), .offset(cpu_offset), .err(cpu_err),
        .ack_data(ack_data)
    );

    hb_bm_decode u_bm (
        .addr(bm_addr), .to_pci(bm_to_pci), .to_sys(bm_to_sys), .err(bm_err),
        .offset(bm_offset)
    );

    hb_irq_route #(.SLOTS(SLOTS), .PINS(PINS), .LINES(4)) u_irq (
        .clk(clk), .rst_n(rst_n), .legacy(legacy_mode), .irq_in(irq_in),
        .irq_line(irq_line), .irq_single(irq_single)
    );

    // R7
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_sel));
    // R6
    err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> (cpu_sel == '0));
    // R5
    rom_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_write) |-> !cpu_sel[RG_ROM]);
    // R8
    bm_one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bm_to_pci, bm_to_sys, bm_err}) == 1);
endmodule

// File: tb/test_hb_bridge.sv
module test_hb_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = '0;
    logic [4:0]  cpu_sel;
    logic [31:0] cpu_offset;
    logic        cpu_err;
    logic [7:0]  irq_vector = 8'h5A;
    logic [7:0]  ack_data;
    logic [31:0] bm_addr = '0;
    logic        bm_to_pci, bm_to_sys, bm_err;
    logic [31:0] bm_offset;
    logic        legacy_mode = 1'b1;
    logic [15:0] irq_in = '0;
    logic [3:0]  irq_line;
    logic        irq_single;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    hb_bridge i_hb_bridge (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cpu(string tag, logic [31:0] a, logic wr, logic [1:0] sz,
                       logic [4:0] esel, logic [31:0] eoff, logic eerr);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a; cpu_write = wr; cpu_size = sz;
        #1;
        chk({tag, " sel"}, 64'(cpu_sel), 64'(esel));
        chk({tag, " err"}, 64'(cpu_err), 64'(eerr));
        if (esel != 0) chk({tag, " off"}, 64'(cpu_offset), 64'(eoff));
    endtask

    task automatic bm(string tag, logic [31:0] a, logic [2:0] exp, logic [31:0] eoff);
        @(negedge clk);
        bm_addr = a;
        #1;
        chk({tag, " target"}, 64'({bm_to_pci, bm_to_sys, bm_err}), 64'(exp));
        if (!exp[0]) chk({tag, " off"}, 64'(bm_offset), 64'(eoff));
    endtask

    task automatic irq(string tag, logic leg, logic [15:0] v);
        logic [3:0] el;
        el = '0;
        for (int d = 0; d < 4; d++)
            for (int n = 0; n < 4; n++)
                if (v[d*4+n]) el[(n+d)&1] = 1'b1;
        @(negedge clk);
        legacy_mode = leg; irq_in = v;
        @(negedge clk);
        chk({tag, " lines"}, 64'(irq_line), leg ? 64'(el) : 64'(0));
        chk({tag, " single"}, 64'(irq_single), leg ? 64'(0) : 64'(|v));
    endtask

    task automatic t_reset();
        irq_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R11 reset lines", 64'(irq_line), 0);
        chk("R11 reset single", 64'(irq_single), 0);
        chk("R6 idle sel", 64'(cpu_sel), 0);
        chk("R6 idle err", 64'(cpu_err), 0);
        irq_in = '0;
        rst_n = 1'b1;
    endtask

    task automatic t_cpu_map();
        cpu("R1 zero", 32'h0000_0000, 0, 2, 5'b00001, 32'h0, 0);
        cpu("R1 top", 32'h7FFF_FFFF, 1, 2, 5'b00001, 32'h7FFF_FFFF, 0);
        cpu("R2 base", 32'h8000_0000, 0, 0, 5'b00010, 32'h0, 0);
        cpu("R2 end", 32'hBF7F_FFFF, 1, 1, 5'b00010, 32'h3F7F_FFFF, 0);
        cpu("R6 gap1", 32'hBF80_0000, 0, 0, 5'b0, 0, 1);
        cpu("R6 below ack", 32'hBFFF_FFEF, 0, 0, 5'b0, 0, 1);
        cpu("R6 above ack", 32'hBFFF_FFF1, 0, 0, 5'b0, 0, 1);
        cpu("R4 base", 32'hC000_0000, 1, 2, 5'b01000, 32'h0, 0);
        cpu("R4 end", 32'hFEFF_FFFF, 0, 2, 5'b01000, 32'h3EFF_FFFF, 0);
        cpu("R6 gap2", 32'hFF00_0000, 0, 0, 5'b0, 0, 1);
        cpu("R6 gap2 end", 32'hFFEF_FFFF, 0, 0, 5'b0, 0, 1);
        cpu("R5 rom base", 32'hFFF0_0000, 0, 2, 5'b10000, 32'h0, 0);
        cpu("R5 rom top", 32'hFFFF_FFFF, 0, 0, 5'b10000, 32'h000F_FFFF, 0);
        cpu("R5 rom write", 32'hFFF8_0000, 1, 2, 5'b0, 0, 1);
        @(negedge clk);
        cpu_valid = 1'b0; cpu_addr = 32'hFF00_0000;
        #1;
        chk("R6 invalid sel", 64'(cpu_sel), 0);
        chk("R6 invalid err", 64'(cpu_err), 0);
    endtask

    task automatic t_ack();
        cpu("R3 ack read", 32'hBFFF_FFF0, 0, 0, 5'b00100, 32'h0, 0);
        chk("R3 ack data", 64'(ack_data), 64'h5A);
        irq_vector = 8'hC3;
        #1;
        chk("R3 ack data2", 64'(ack_data), 64'hC3);
        cpu("R3 ack wide", 32'hBFFF_FFF0, 0, 1, 5'b0, 0, 1);
        chk("R3 ack wide data", 64'(ack_data), 0);
        cpu("R3 ack word", 32'hBFFF_FFF0, 0, 2, 5'b0, 0, 1);
        cpu("R3 ack write", 32'hBFFF_FFF0, 1, 0, 5'b0, 0, 1);
        chk("R3 ack write data", 64'(ack_data), 0);
        cpu("R7 back to sys", 32'h0000_1234, 0, 0, 5'b00001, 32'h1234, 0);
    endtask

    task automatic t_bm();
        bm("R8 low", 32'h0000_0000, 3'b100, 32'h0);
        bm("R8 pci end", 32'h3EFF_FFFF, 3'b100, 32'h3EFF_FFFF);
        bm("R8 gap lo", 32'h3F00_0000, 3'b001, 0);
        bm("R8 gap hi", 32'h7FFF_FFFF, 3'b001, 0);
        bm("R8 sys base", 32'h8000_0000, 3'b010, 32'h0);
        bm("R8 sys top", 32'hFFFF_FFFF, 3'b010, 32'h7FFF_FFFF);
    endtask

    task automatic t_irq();
        for (int i = 0; i < 16; i++) irq("R9 legacy one pin", 1'b1, 16'(1) << i);
        irq("R9 legacy mix", 1'b1, 16'h8421);
        irq("R9 legacy none", 1'b1, 16'h0000);
        for (int i = 0; i < 16; i++) irq("R10 merged one pin", 1'b0, 16'(1) << i);
        irq("R10 merged none", 1'b0, 16'h0000);
        irq("R10 merged all", 1'b0, 16'hFFFF);
        irq("R9 back to legacy", 1'b1, 16'h0030);
        @(negedge clk);
        irq_in = 16'h0001;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 mid reset lines", 64'(irq_line), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_cpu_map();
        t_ack();
        t_bm();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule